// File: doc/BRIEF.md
# Synthesizer Loop Divider and Phase-Lock Core

This block is the digital heart of a tuning synthesizer loop. A crystal-derived reference is divided down by one of three selectable ratios (512, 640 or 1024). The output of an external fixed divide-by-eight prescaler is divided by a 15-bit programmable word. The two divided edges are compared in a tri-state phase/frequency detector. The detector drives pump-up and pump-down pulses towards an external charge pump. A lock detector watches the width of those pulses and drives an active-low lock pin. In test mode the same pin carries the divided reference or a half-rate copy of the divided VCO signal.

Everything runs on one system clock. The crystal and prescaler edges arrive as single-cycle enables, `ref_tick` and `vco_tick`. The tuning step is eight times the comparison rate. With a 4 MHz crystal, the comparison rates are 7.8125 kHz (ratio 512), 6.25 kHz (ratio 640) and 3.90625 kHz (ratio 1024). A new divider word or ratio takes effect only at the terminal count of the division cycle in progress, so no truncated period is produced. The charge-pump current choice (low or high) is handed through as a registered level.

Top module: `pll_core`

## Requirements
- R1: While `rst_n` is low and in the cycle after it, `pump_up` and `pump_dn` are 0 and `lock_n` is 1 (with `test_en` = 0). The active reference ratio after reset is 640, so the first reference pulse follows the 640th `ref_tick`.
- R2: `ratio_sel` encodes 2'b01 = 512, 2'b10 = 1024, and 2'b00 or 2'b11 = 640. With the ratio in force, the reference divider emits one single-cycle pulse every ratio `ref_tick`s. The pulse comes one clock after the terminal tick.
- R3: The main divider emits one pulse every N `vco_tick`s, where N = `div_word`, and a word of 0 means 32768. After reset the first pulse follows the first `vco_tick`.
- R4: A changed `ratio_sel` or `div_word` is sampled only at the terminal count of the current division. The period in progress keeps its old length, and the following period uses the new one.
- R5: A reference pulse sets `pump_up` and a divided pulse sets `pump_dn`, each one clock later. When both have been seen, both clear, so a coincident pair produces no pulse. `pump_up` and `pump_dn` are never high together.
- R6: Lock is declared after 4 consecutive comparison cycles in which no pump pulse lasted LOCK_WIN (default 8) clocks. A comparison cycle is the interval ending at each reference pulse.
- R7: Lock is dropped one clock after a pump pulse reaches LOCK_WIN clocks. The consecutive-cycle count then restarts from zero.
- R8: With `test_en` = 0, `lock_n` is 0 while locked and 1 otherwise.
- R9: With `test_en` = 1, `lock_n` shows the reference pulse when `test_sel` = 0. When `test_sel` = 1 it shows a level that toggles with every divided pulse (half the divided rate).
- R10: `cp_hi_out` equals `cp_hi` delayed by one clock (1 = high current, 0 = low current).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable per crystal edge |
| vco_tick | input | 1 | One-cycle enable per prescaled VCO edge |
| div_word | input | 15 | Main divider value (0 means 32768) |
| ratio_sel | input | 2 | Reference ratio select |
| cp_hi | input | 1 | Charge-pump current select |
| test_en | input | 1 | Lock pin carries a test signal |
| test_sel | input | 1 | Test signal choice: 0 reference, 1 half divided |
| pump_up | output | 1 | Charge-pump up pulse |
| pump_dn | output | 1 | Charge-pump down pulse |
| cp_hi_out | output | 1 | Registered charge-pump current select |
| lock_n | output | 1 | Active-low lock flag or test output |

## Verification
The assertions take the ratios to be at least 2, so reference pulses can never occur on adjacent clocks. They also assume that only a lock-window overrun or a reference pulse moves the lock state. The stimulus keeps `ref_tick` and `vco_tick` as plain enables sampled on the clock. Ratio and word changes are applied at falling edges, in mid-period, so deferral can be observed directly. Phases are arranged so that the loop locks, then loses lock under a slow drift, and then crosses from pump-down to pump-up. A random `vco_tick` pattern at the end exercises arbitrary phase relations against the cycle model.

// File: rtl/pll_core_pkg.sv
// Package: shared encodings for the synthesizer loop core.
package pll_core_pkg;
    typedef enum logic [1:0] {
        RSEL_MID  = 2'b00,
        RSEL_LO   = 2'b01,
        RSEL_HI   = 2'b10,
        RSEL_MIDB = 2'b11
    } ratio_sel_e;
endpackage

// File: rtl/pll_ref_div.sv
// Reference divider: counts ref_tick enables down from the active ratio and
// emits a registered one-cycle pulse at terminal count. The ratio select is
// sampled only at terminal count. Assumes all ratios are at least 2.
module pll_ref_div
    import pll_core_pkg::*;
#(
    parameter int R_LO  = 512,
    parameter int R_MID = 640,
    parameter int R_HI  = 1024,
    localparam int CW   = $clog2(R_HI)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] ratio_sel,
    output logic       ref_pulse
);
    logic [CW-1:0] cnt;
    logic [CW:0]   ratio_q;
    logic [CW:0]   sel_ratio;
    logic          term;

    // Purpose: decode the requested ratio.
    always_comb begin
        case (ratio_sel_e'(ratio_sel))
            RSEL_LO: sel_ratio = (CW+1)'(R_LO);
            RSEL_HI: sel_ratio = (CW+1)'(R_HI);
            default: sel_ratio = (CW+1)'(R_MID);
        endcase
    end

    assign term = tick && (cnt == '0);

    // Purpose: count down, reload at terminal count, register the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= CW'(R_MID - 1);
            ratio_q   <= (CW+1)'(R_MID);
            ref_pulse <= 1'b0;
        end else begin
            ref_pulse <= term;
            if (term) begin
                ratio_q <= sel_ratio;
                cnt     <= CW'(sel_ratio - (CW+1)'(1));
            end else if (tick) begin
                cnt <= cnt - CW'(1);
            end
        end
    end

    assert_ratio_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_q == (CW+1)'(R_LO)) || (ratio_q == (CW+1)'(R_MID)) || (ratio_q == (CW+1)'(R_HI)));

    assert_ref_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);
endmodule

// File: rtl/pll_main_div.sv
// Main programmable divider: counts vco_tick enables, reloads from the word
// at terminal count (word 0 gives 2**DW) and emits a registered pulse plus a
// half-rate toggle. The word is sampled only at terminal count.
module pll_main_div #(
    parameter int DW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [DW-1:0] word,
    output logic          div_pulse,
    output logic          div_half
);
    logic [DW-1:0] cnt;
    logic          term;

    assign term = tick && (cnt == '0);

    // Purpose: count down, reload from the word, register pulse and toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            div_pulse <= 1'b0;
            div_half  <= 1'b0;
        end else begin
            div_pulse <= term;
            if (term) begin
                cnt      <= word - DW'(1);
                div_half <= ~div_half;
            end else if (tick) begin
                cnt <= cnt - DW'(1);
            end
        end
    end

    assert_half_follows_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_pulse) |-> !$stable(div_half));
endmodule

// File: rtl/pll_pfd.sv
// Tri-state phase/frequency detector: two set flops cleared together once
// both edges have been seen. Inputs are single-cycle pulses.
module pll_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse,
    input  logic div_pulse,
    output logic up,
    output logic dn
);
    logic up_nx, dn_nx;

    assign up_nx = up | ref_pulse;
    assign dn_nx = dn | div_pulse;

    // Purpose: set on each edge, clear both when both are pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else if (up_nx && dn_nx) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else begin
            up <= up_nx;
            dn <= dn_nx;
        end
    end

    assert_pump_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && dn));

    assert_up_on_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pulse && !div_pulse && !dn) |=> up);
endmodule

// File: rtl/pll_lock_det.sv
// Lock detector: measures each pump pulse in clocks. A pulse reaching WIN
// clocks drops lock at once; NCYC clean comparison cycles (closed by each
// reference pulse) declare lock. Assumes WIN >= 2.
module pll_lock_det #(
    parameter int WIN  = 8,
    parameter int NCYC = 4,
    localparam int WW  = $clog2(WIN),
    localparam int GW  = $clog2(NCYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up,
    input  logic dn,
    input  logic ref_pulse,
    output logic locked
);
    logic [WW-1:0] wcnt;
    logic [GW-1:0] good;
    logic          bad;
    logic          active, too_wide, spoiled;
    logic [GW-1:0] good_nx;

    assign active   = up | dn;
    assign too_wide = active && (wcnt == WW'(WIN - 1));
    assign spoiled  = bad | too_wide;
    assign good_nx  = spoiled ? '0 : ((good == GW'(NCYC)) ? good : good + GW'(1));

    // Purpose: measure the width of the current pump pulse, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wcnt <= '0;
        else if (!active)
            wcnt <= '0;
        else if (!too_wide)
            wcnt <= wcnt + WW'(1);
    end

    // Purpose: count clean comparison cycles and maintain the lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good   <= '0;
            bad    <= 1'b0;
            locked <= 1'b0;
        end else if (ref_pulse) begin
            bad    <= 1'b0;
            good   <= good_nx;
            locked <= (good_nx == GW'(NCYC));
        end else if (too_wide) begin
            bad    <= 1'b1;
            good   <= '0;
            locked <= 1'b0;
        end
    end

    assert_lock_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        too_wide |=> !locked);

    assert_lock_needs_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (good == GW'(NCYC)));
endmodule

// File: rtl/pll_core.sv
// Top: synthesizer loop divider and phase-lock core. Assumes ref_tick and
// vco_tick are single-cycle enables synchronous to clk.
module pll_core #(
    parameter int R_LO     = 512,
    parameter int R_MID    = 640,
    parameter int R_HI     = 1024,
    parameter int DW       = 15,
    parameter int LOCK_WIN = 8,
    parameter int LOCK_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_tick,
    input  logic          vco_tick,
    input  logic [DW-1:0] div_word,
    input  logic [1:0]    ratio_sel,
    input  logic          cp_hi,
    input  logic          test_en,
    input  logic          test_sel,
    output logic          pump_up,
    output logic          pump_dn,
    output logic          cp_hi_out,
    output logic          lock_n
);
    logic ref_pulse, div_pulse, div_half, locked;

    pll_ref_div #(.R_LO(R_LO), .R_MID(R_MID), .R_HI(R_HI)) u_ref (
        .clk(clk), .rst_n(rst_n), .tick(ref_tick), .ratio_sel(ratio_sel),
        .ref_pulse(ref_pulse));

    pll_main_div #(.DW(DW)) u_main (
        .clk(clk), .rst_n(rst_n), .tick(vco_tick), .word(div_word),
        .div_pulse(div_pulse), .div_half(div_half));

    pll_pfd u_pfd (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .div_pulse(div_pulse),
        .up(pump_up), .dn(pump_dn));

    pll_lock_det #(.WIN(LOCK_WIN), .NCYC(LOCK_CYC)) u_lock (
        .clk(clk), .rst_n(rst_n), .up(pump_up), .dn(pump_dn),
        .ref_pulse(ref_pulse), .locked(locked));

    // Purpose: register the charge-pump current select.
    always_ff @(posedge clk) begin
        if (!rst_n) cp_hi_out <= 1'b0;
        else        cp_hi_out <= cp_hi;
    end

    // Purpose: select the lock pin source.
    always_comb begin
        if (!test_en)      lock_n = ~locked;
        else if (test_sel) lock_n = div_half;
        else               lock_n = ref_pulse;
    end

    assert_cp_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cp_hi_out == $past(cp_hi)));
endmodule

// File: tb/pll_core_test.sv
module pll_core_test;
    localparam int WIN = 8;
    localparam int NCY = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0, vco_tick = 1'b0;
    logic [14:0] div_word = 15'd640;
    logic [1:0]  ratio_sel = 2'b00;
    logic        cp_hi = 1'b0, test_en = 1'b0, test_sel = 1'b0;
    logic        pump_up, pump_dn, cp_hi_out, lock_n;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pll_core uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .vco_tick(vco_tick),
        .div_word(div_word), .ratio_sel(ratio_sel), .cp_hi(cp_hi),
        .test_en(test_en), .test_sel(test_sel), .pump_up(pump_up),
        .pump_dn(pump_dn), .cp_hi_out(cp_hi_out), .lock_n(lock_n));

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural cycle model.
    int m_rcnt, m_dcnt, m_w, m_good;
    bit m_refp, m_divp, m_up, m_dn, m_half, m_bad, m_locked, m_cp;

    function automatic int ratio_of(input logic [1:0] s);
        if (s == 2'b01) return 512;
        if (s == 2'b10) return 1024;
        return 640;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rcnt = 639; m_dcnt = 0; m_w = 0; m_good = 0;
            m_refp = 0; m_divp = 0; m_up = 0; m_dn = 0; m_half = 0;
            m_bad = 0; m_locked = 0; m_cp = 0;
        end else begin
            bit n_refp, n_divp, u, d, act, tw, spoil;
            n_refp = ref_tick && m_rcnt == 0;
            if (ref_tick) m_rcnt = (m_rcnt == 0) ? ratio_of(ratio_sel) - 1 : m_rcnt - 1;
            n_divp = vco_tick && m_dcnt == 0;
            if (vco_tick) begin
                if (m_dcnt == 0) begin
                    m_dcnt = ((div_word == 0) ? 32768 : int'(div_word)) - 1;
                    m_half = !m_half;
                end else m_dcnt = m_dcnt - 1;
            end
            u = m_up || m_refp;
            d = m_dn || m_divp;
            if (u && d) begin u = 0; d = 0; end
            act = m_up || m_dn;
            tw = act && m_w == WIN - 1;
            spoil = m_bad || tw;
            if (m_refp) begin
                m_bad = 0;
                if (spoil) m_good = 0;
                else if (m_good < NCY) m_good++;
                m_locked = !spoil && m_good == NCY;
            end else if (tw) begin
                m_bad = 1; m_good = 0; m_locked = 0;
            end
            m_w = !act ? 0 : (tw ? m_w : m_w + 1);
            m_up = u; m_dn = d; m_refp = n_refp; m_divp = n_divp; m_cp = cp_hi;
        end
    end

    // Compare every cycle, shortly after the edge.
    always @(posedge clk) begin
        #1;
        if (!done) begin
            bit exp_lock;
            exp_lock = !test_en ? !m_locked : (test_sel ? m_half : m_refp);
            chk("R5 pump_up", pump_up, m_up);
            chk("R5 pump_dn", pump_dn, m_dn);
            chk("R10 cp_hi_out", cp_hi_out, m_cp);
            chk(test_en ? "R9 lock_n test" : "R8 lock_n", lock_n, exp_lock);
        end
    end

    bit saw_up, saw_dn;
    always @(negedge clk) begin
        if (pump_up) saw_up = 1;
        if (pump_dn) saw_dn = 1;
    end

    task automatic wait_hi();
        do @(negedge clk); while (lock_n !== 1'b1);
    endtask

    task automatic gap_hi(output int g);
        g = 0;
        do begin @(negedge clk); g++; end while (lock_n !== 1'b1);
    endtask

    task automatic gap_tog(output int g);
        logic v;
        v = lock_n;
        g = 0;
        do begin @(negedge clk); g++; end while (lock_n === v);
    endtask

    initial begin
        int g;
        repeat (3) @(negedge clk);
        chk("R1 pump_up in reset", pump_up, 0);
        chk("R1 pump_dn in reset", pump_dn, 0);
        chk("R1 lock_n in reset", lock_n, 1);
        ref_tick = 1;
        rst_n = 1;
        @(negedge clk);
        chk("R1 lock_n after reset", lock_n, 1);
        repeat (638) @(negedge clk);
        vco_tick = 1;                       // aligned with the 640th ref tick
        repeat (2000 - 640) @(negedge clk);
        chk("R6 not locked after 3 clean cycles", lock_n, 1);
        repeat (1200) @(negedge clk);
        chk("R6 locked after 4 clean cycles", lock_n, 0);
        chk("R5 no pump pulse when aligned", int'(saw_up || saw_dn), 0);

        div_word = 15'd630;                 // divided edge leads by 10 more each cycle
        repeat (640 * 3) @(negedge clk);
        chk("R7 lock dropped on wide pulse", lock_n, 1);
        chk("R5 pump_dn seen when divided leads", int'(saw_dn), 1);
        chk("R5 pump_up not seen when divided leads", int'(saw_up), 0);
        div_word = 15'd650;
        repeat (640 * 10) @(negedge clk);
        chk("R5 pump_up seen when reference leads", int'(saw_up), 1);

        cp_hi = 1;
        @(negedge clk);
        chk("R10 cp_hi_out high", cp_hi_out, 1);
        cp_hi = 0;
        @(negedge clk);
        chk("R10 cp_hi_out low", cp_hi_out, 0);

        test_en = 1; test_sel = 0;
        wait_hi();
        gap_hi(g); chk("R2 ratio 640 gap", g, 640);
        ratio_sel = 2'b01;
        gap_hi(g); chk("R4 ratio change deferred", g, 640);
        gap_hi(g); chk("R2 ratio 512 gap", g, 512);
        ratio_sel = 2'b10;
        gap_hi(g); chk("R4 ratio change deferred 512", g, 512);
        gap_hi(g); chk("R2 ratio 1024 gap", g, 1024);
        ratio_sel = 2'b11;
        gap_hi(g);
        gap_hi(g); chk("R2 ratio code 11 gives 640", g, 640);

        test_sel = 1;
        div_word = 15'd100;
        gap_tog(g);
        gap_tog(g);
        gap_tog(g); chk("R3 divide by 100", g, 100);
        div_word = 15'd50;
        gap_tog(g); chk("R4 word change deferred", g, 100);
        gap_tog(g); chk("R3 divide by 50", g, 50);
        div_word = 15'd0;
        gap_tog(g);
        gap_tog(g); chk("R3 word 0 divides by 32768", g, 32768);
        div_word = 15'd37;

        test_en = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            vco_tick = ($urandom_range(0, 3) != 0);
            if (i % 700 == 0) test_en = !test_en;
        end
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done = 1;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule